// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire control link. A host lowers the active-low select, toggles a serial clock and moves bits over a single data line. The line carries commands and addresses from the host, and carries read data back to it. Every frame is sixteen bits long and is shifted most significant bit first. It holds a 4-bit command nibble, then a 4-bit register address, then an 8-bit data byte. The port owns a file of sixteen 8-bit configuration registers and presents all of them in parallel to the logic around it.

A fast system clock samples the select, serial clock and data inputs. Input bits are taken on rising serial-clock edges. The shared pin is split into an input, an output and an output enable; the pad ring combines them into the physical pin. The enable is raised only while the byte requested by a read is being returned. That byte goes out in the eight clocks that follow the read command frame, with each bit changing on a falling edge. Register 0xA is the gain dwell timer and starts at 0x0D. All other registers start at zero.

Top module: `serial_reg_port`

## Requirements
- R1: A frame is 16 bits, MSB first: command in bits 15..12, address in bits 11..8, data in bits 7..0. Command 0x1 stores the data byte in the addressed register, which appears on `cfg_regs[8*addr +: 8]`.
- R2: Command 0x2 sends its data byte as zeros. On the next eight serial clocks the addressed register is returned MSB first on `sdo`, which changes on falling edges and is sampled by the host on rising edges.
- R3: `sdo_en` stays low during command frames and while select is high. It is high only during the eight-clock read-data phase.
- R4: Command 0x0 and commands 0x4 through 0xF leave every register unchanged.
- R5: Command 0x3 returns register 0xA to 0x0D and all other registers to 0x00, and restarts framing.
- R6: After `rst_n` is released, the registers hold the same defaults as in R5 and `sdo_en` is low.
- R7: Raising select in the middle of a frame or a read-data phase discards the partial frame, releases the pin, and makes the next selection start at a fresh frame.
- R8: A write changes no register before its sixteenth bit is taken. Registers never change while select is high.
- R9: While select stays low, frames follow one another: the next frame starts after a completed frame, or after the eight clocks of a read-data phase.
- R10: While `sdo_en` is high, `sdo` holds its value through each high half of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from host |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Data line as seen by the port (input side of pad) |
| sdo | output | 1 | Read data toward the data line |
| sdo_en | output | 1 | Drive enable for the shared data pad |
| cfg_regs | output | 128 | All sixteen registers, register n in bits 8n+7..8n |

## Verification
The assertions assume that each level of the serial clock and select lasts several system clocks. In particular, the serial clock is low when the pad enable turns on, and select stays high for at least three system clocks before register stability is required. The bench holds every serial clock half period for four system clocks. It changes select only while the serial clock is low, and it drives the data line only while the enable is low. Read results are compared by a monitor against a queue of expected bytes that the driver fills. Write, no-effect and abort cases are compared against a model register array through the parallel output.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int CW = 4,
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [3:0] DWELL_ADDR = 4'hA,
  parameter logic [7:0] DWELL_RST = 8'h0D
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_en,
  output logic [(1<<AW)*DW-1:0]  cfg_regs
);
  localparam int FW   = CW + AW + DW;
  localparam int NR   = 1 << AW;
  localparam int CNTW = $clog2(FW + 1);
  localparam int TXW  = $clog2(DW + 1);

  localparam logic [CW-1:0] CMD_WR  = CW'(1);
  localparam logic [CW-1:0] CMD_RD  = CW'(2);
  localparam logic [CW-1:0] CMD_RST = CW'(3);

  logic cs_s, sclk_s, sclk_d, sdi_s;
  logic rise, fall;
  logic [FW-1:0]   sr;
  logic [FW-1:0]   frame_in;
  logic [CNTW-1:0] bitcnt;
  logic            txmode;
  logic [TXW-1:0]  txcnt;
  logic [DW-1:0]   txsr;
  logic [DW-1:0]   rf [NR];
  logic            last;
  logic [CW-1:0]   cmd;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   wdat;

  function automatic logic [DW-1:0] reset_val(input int idx);
    return (idx == int'(DWELL_ADDR)) ? DW'(DWELL_RST) : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s   <= 1'b1;
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
      sdi_s  <= 1'b0;
    end else begin
      cs_s   <= cs_n;
      sclk_s <= sclk;
      sclk_d <= sclk_s;
      sdi_s  <= sdi;
    end
  end

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign frame_in = {sr[FW-2:0], sdi_s};
  assign last     = rise && !cs_s && !txmode && (bitcnt == CNTW'(FW - 1));
  assign cmd      = frame_in[FW-1 -: CW];
  assign addr     = frame_in[DW +: AW];
  assign wdat     = frame_in[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) rf[i] <= reset_val(i);
    end else if (last && cmd == CMD_RST) begin
      for (int i = 0; i < NR; i++) rf[i] <= reset_val(i);
    end else if (last && cmd == CMD_WR) begin
      rf[addr] <= wdat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      bitcnt <= '0;
      txmode <= 1'b0;
      txcnt  <= '0;
      txsr   <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (cs_s) begin
      bitcnt <= '0;
      txmode <= 1'b0;
      txcnt  <= '0;
      sdo_en <= 1'b0;
    end else if (rise && !txmode) begin
      sr <= frame_in;
      if (last) begin
        bitcnt <= '0;
        if (cmd == CMD_RD) begin
          txmode <= 1'b1;
          txcnt  <= '0;
          txsr   <= rf[addr];
        end
      end else begin
        bitcnt <= bitcnt + 1'b1;
      end
    end else if (rise && txmode) begin
      if (txcnt == TXW'(DW - 1)) begin
        txmode <= 1'b0;
        txcnt  <= '0;
        sdo_en <= 1'b0;
      end else begin
        txcnt <= txcnt + 1'b1;
      end
    end else if (fall && txmode) begin
      sdo    <= txsr[DW-1];
      txsr   <= {txsr[DW-2:0], 1'b0};
      sdo_en <= 1'b1;
    end
  end

  for (genvar g = 0; g < NR; g++) begin : g_out
    assign cfg_regs[g*DW +: DW] = rf[g];
  end
endmodule

module serial_reg_port_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         sclk,
  input logic         sdo,
  input logic         sdo_en,
  input logic [W-1:0] cfg_regs
);
  assert_pin_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_en);

  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> $stable(cfg_regs));

  assert_enable_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> !sclk);

  assert_sdo_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && $past(sdo_en) && sclk && $past(sclk) && $past(sclk, 2)) |-> $stable(sdo));
endmodule

bind serial_reg_port serial_reg_port_chk #(.W((1 << AW) * DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .sdo(sdo), .sdo_en(sdo_en), .cfg_regs(cfg_regs)
);

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi;
  logic sdo, sdo_en;
  logic [127:0] cfg_regs;

  int vec = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] model [16];
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  serial_reg_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .cfg_regs(cfg_regs)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) model[i] = (i == 10) ? 8'h0D : 8'h00;
  endtask

  task automatic check_all(input string tag);
    logic [127:0] e;
    for (int i = 0; i < 16; i++) e[i*8 +: 8] = model[i];
    chk(cfg_regs === e, tag, cfg_regs, e);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    half();
  endtask

  task automatic desel();
    half();
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic shift_bits(input logic [15:0] f, input int hi, input int lo, input string tag);
    for (int i = hi; i >= lo; i--) begin
      sdi = f[i];
      half();
      sclk = 1'b1;
      if (i == lo) chk(sdo_en === 1'b0, tag, sdo_en, 0);
      half();
      sclk = 1'b0;
    end
    sdi = 1'b0;
  endtask

  task automatic frame(input logic [3:0] c, input logic [3:0] a, input logic [7:0] d);
    shift_bits({c, a, d}, 15, 0, "R3 enable low in command frame");
    if (c == 4'h1) model[a] = d;
    if (c == 4'h3) model_reset();
  endtask

  task automatic read_phase(input int n);
    for (int i = 0; i < n; i++) begin
      half();
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
  endtask

  task automatic rd(input logic [3:0] a);
    exp_q.push_back(model[a]);
    shift_bits({4'h2, a, 8'h00}, 15, 0, "R3 enable low in read command");
    read_phase(8);
  endtask

  int mcnt = 0;
  logic [7:0] mbyte;
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) mcnt = 0;
    else if (sdo_en) begin
      mbyte = {mbyte[6:0], sdo};
      mcnt++;
      if (mcnt == 8) begin
        mcnt = 0;
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected read data", mbyte, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(mbyte === e, "R2 read data", mbyte, e);
        end
      end
    end
  end

  always @(negedge sclk) begin
    if (sdo_en && mcnt > 0) chk(sdo === mbyte[0], "R10 sdo steady while sclk high", sdo, mbyte[0]);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half();
    check_all("R6 power-up defaults");
    chk(sdo_en === 1'b0, "R6 enable low after reset", sdo_en, 0);

    sel(); frame(4'h1, 4'h3, 8'hA5); desel();
    check_all("R1 write reg3");
    sel(); frame(4'h1, 4'hF, 8'h5A); desel();
    sel(); frame(4'h1, 4'h0, 8'h81); desel();
    check_all("R1 write reg15 and reg0");

    sel(); rd(4'h3); desel();
    sel(); rd(4'hA); desel();
    sel(); rd(4'hF); desel();
    chk(sdo_en === 1'b0, "R3 enable low after deselect", sdo_en, 0);

    sel();
    frame(4'h1, 4'h5, 8'h3C);
    rd(4'h5);
    frame(4'h1, 4'h6, 8'hC3);
    rd(4'h6);
    rd(4'h0);
    desel();
    check_all("R9 back-to-back frames");

    sel();
    frame(4'h0, 4'h3, 8'hFF);
    frame(4'h4, 4'h3, 8'h11);
    frame(4'h9, 4'h5, 8'h22);
    frame(4'hF, 4'hA, 8'h33);
    desel();
    check_all("R4 unused commands no effect");

    sel(); shift_bits({4'h1, 4'h3, 8'h77}, 15, 6, "R7 partial write"); desel();
    check_all("R7 aborted write no effect");
    sel(); frame(4'h1, 4'h2, 8'h99); desel();
    check_all("R7 fresh frame after abort");

    sel();
    shift_bits({4'h2, 4'h3, 8'h00}, 15, 0, "R3 enable low in read command");
    read_phase(3);
    desel();
    chk(sdo_en === 1'b0, "R7 pin released after aborted read", sdo_en, 0);
    sel(); rd(4'h2); desel();

    sel();
    shift_bits({4'h1, 4'h7, 8'hE4}, 15, 1, "R8 write in progress");
    half();
    check_all("R8 no write before bit 16");
    shift_bits({4'h1, 4'h7, 8'hE4}, 0, 0, "R8 last bit");
    model[7] = 8'hE4;
    half();
    check_all("R8 write after bit 16");
    desel();

    sel(); frame(4'h1, 4'hA, 8'h42); frame(4'h3, 4'h0, 8'h00); desel();
    check_all("R5 master reset defaults");
    sel(); rd(4'hA); rd(4'h7); desel();

    half();
    chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule